// File: doc/BRIEF.md
# Stopwatch BCD Time Counter

This block keeps time for a stopwatch whose smallest unit is one tenth of a second. Everything runs on a single 50 MHz system clock. A prescaler inside the block raises a one-cycle advance pulse every 0.1 s. That pulse walks a six-digit BCD cascade shaped as H.MM.SS.t, which reads, from least to most significant: tenths, seconds units, seconds tens, minutes units, minutes tens and a single hour-style top digit.

A level input `run_i` lets the cascade count while high. While it is low the cascade freezes, and so does the prescaler, so a pause loses no part of a tenth. An active-low reset clears the digits and the prescaler. The six digits leave as 4-bit BCD values for a separate display stage. A one-cycle flag marks the moment the whole time wraps back to zero.

Top module: `sw_time_chain`

## Requirements
- R1: While `rst_n` is low, all six digit outputs read 0 and `wrap_o` is 0. The prescaler is cleared at the same time.
- R2: With `run_i` held high after reset release, the tenths digit first changes exactly TICK_DIV clock cycles after release. After that it advances once per TICK_DIV cycles. The default of 5,000,000 gives 0.1 s at 50 MHz.
- R3: While `run_i` is low, no digit changes and the prescaler keeps its count. The number of advances therefore equals the whole number of TICK_DIV periods of accumulated run-high cycles.
- R4: The tenths digit counts 0 through 9 and then returns to 0. The top digit counts 0 through TOP_MAX (default 9) and then returns to 0.
- R5: The minutes pair counts 00 through 59. Its tens digit never exceeds 5, and it returns to 00 after 59.
- R6: A digit moves only on an advance pulse in which every less significant digit sits at its own maximum. All digits that roll over do so in the same clock cycle. The seconds pair counts 00 through 59 in this way.
- R7: On the advance pulse that leaves TOP_MAX.59.59.9, every digit becomes 0. `wrap_o` is then high for exactly the one cycle after that edge.
- R8: No digit ever holds a value above its limit: 9 for the tenths and units digits, 5 for the tens digits, TOP_MAX for the top digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| run_i | input | 1 | High: count; low: pause |
| tenths_o | output | 4 | Tenths-of-a-second digit, BCD |
| sec_lo_o | output | 4 | Seconds units digit, BCD |
| sec_hi_o | output | 4 | Seconds tens digit, 0 to 5 |
| min_lo_o | output | 4 | Minutes units digit, BCD |
| min_hi_o | output | 4 | Minutes tens digit, 0 to 5 |
| top_o | output | 4 | Top digit, 0 to TOP_MAX |
| wrap_o | output | 1 | One-cycle pulse after the full time wraps to zero |

## Verification
The bench builds two instances that share one set of inputs. The first uses TICK_DIV = 1 and TOP_MAX = 1, so it advances on every run-high cycle and completes a full wrap through 1.59.59.9 in 72,000 cycles. This brings the end-of-range rollover and the wrap pulse within reach. The second uses TICK_DIV = 5 with the default top limit, so the exact prescaler phase shows up. This covers the first advance after reset and the prescaler keeping its fraction of a period across pauses.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef logic [3:0] bcd_t;

  localparam int NDIG = 6;

  // Digit positions: 0 tenths, 1 sec units, 2 sec tens,
  // 3 min units, 4 min tens, 5 top digit.
  function automatic int digit_limit(input int idx, input int top_max);
    if (idx == 2 || idx == 4) return 5;
    if (idx == NDIG - 1)      return top_max;
    return 9;
  endfunction

endpackage

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
  parameter int TICK_DIV = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = run_i && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> run_i);

  assert_prescale_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));

  assert_prescale_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit
  import sw_pkg::*;
#(
  parameter int MAX_VAL = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output bcd_t val_o,
  output logic at_max_o
);

  localparam bcd_t TOP = bcd_t'(MAX_VAL);

  bcd_t val_q, val_d;

  assign at_max_o = (val_q == TOP);
  assign val_o    = val_q;

  always_comb begin
    val_d = val_q;
    if (adv_i) begin
      if (at_max_o) val_d = '0;
      else          val_d = val_q + bcd_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assert_digit_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    val_q <= TOP);

  assert_digit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(val_q));

  assert_digit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !at_max_o) |=> (val_q == bcd_t'($past(val_q) + bcd_t'(1))));

  assert_digit_roll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && at_max_o) |=> (val_q == '0));

endmodule

// File: rtl/sw_time_chain.sv
module sw_time_chain
  import sw_pkg::*;
#(
  parameter int TICK_DIV = 5_000_000,
  parameter int TOP_MAX  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  output logic [3:0] tenths_o,
  output logic [3:0] sec_lo_o,
  output logic [3:0] sec_hi_o,
  output logic [3:0] min_lo_o,
  output logic [3:0] min_hi_o,
  output logic [3:0] top_o,
  output logic       wrap_o
);

  logic            tick;
  logic [NDIG:0]   adv;
  logic [NDIG-1:0] at_max;
  bcd_t            digs [NDIG];
  logic            wrap_q, wrap_d;

  sw_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_i),
    .tick_o (tick)
  );

  assign adv[0] = tick;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    localparam int LIM = digit_limit(i, TOP_MAX);
    sw_bcd_digit #(.MAX_VAL(LIM)) u_dig (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv_i    (adv[i]),
      .val_o    (digs[i]),
      .at_max_o (at_max[i])
    );
    assign adv[i+1] = adv[i] && at_max[i];
  end

  assign wrap_d = adv[NDIG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrap_q <= 1'b0;
    else        wrap_q <= wrap_d;
  end

  assign tenths_o = digs[0];
  assign sec_lo_o = digs[1];
  assign sec_hi_o = digs[2];
  assign min_lo_o = digs[3];
  assign min_hi_o = digs[4];
  assign top_o    = digs[5];
  assign wrap_o   = wrap_q;

  assert_wrap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (tenths_o == 4'd0 && sec_lo_o == 4'd0 && sec_hi_o == 4'd0 &&
                min_lo_o == 4'd0 && min_hi_o == 4'd0 && top_o == 4'd0));

  assert_wrap_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o);

  assert_min_tens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    min_hi_o <= 4'd5);

endmodule

// File: tb/sim_sw_time_chain.sv
module sim_sw_time_chain;

  localparam int DIV0 = 1, TOP0 = 1;
  localparam int DIV1 = 5, TOP1 = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] a0, a1, a2, a3, a4, a5, b0, b1, b2, b3, b4, b5;
  logic       aw, bw;

  sw_time_chain #(.TICK_DIV(DIV0), .TOP_MAX(TOP0)) u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .tenths_o(a0), .sec_lo_o(a1), .sec_hi_o(a2),
    .min_lo_o(a3), .min_hi_o(a4), .top_o(a5), .wrap_o(aw));

  sw_time_chain #(.TICK_DIV(DIV1), .TOP_MAX(TOP1)) u1 (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .tenths_o(b0), .sec_lo_o(b1), .sec_hi_o(b2),
    .min_lo_o(b3), .min_hi_o(b4), .top_o(b5), .wrap_o(bw));

  int checks = 0, fails = 0, cycles = 0, wraps0 = 0;
  bit done = 0;

  // Bench model: prescale phase, tick total, expected wrap flag
  int pc0 = 0, t0 = 0, pc1 = 0, t1 = 0;
  bit ew0 = 0, ew1 = 0;
  localparam int MT0 = 36000 * (TOP0 + 1);
  localparam int MT1 = 36000 * (TOP1 + 1);

  always @(posedge clk) begin
    if (!rst_n) begin
      pc0 <= 0; t0 <= 0; ew0 <= 0;
      pc1 <= 0; t1 <= 0; ew1 <= 0;
    end else begin
      ew0 <= run && (pc0 == DIV0 - 1) && (t0 == MT0 - 1);
      ew1 <= run && (pc1 == DIV1 - 1) && (t1 == MT1 - 1);
      if (run) begin
        if (pc0 == DIV0 - 1) begin pc0 <= 0; t0 <= (t0 == MT0 - 1) ? 0 : t0 + 1; end
        else pc0 <= pc0 + 1;
        if (pc1 == DIV1 - 1) begin pc1 <= 0; t1 <= (t1 == MT1 - 1) ? 0 : t1 + 1; end
        else pc1 <= pc1 + 1;
      end
    end
  end

  function automatic int exp_dig(int t, int idx, int tm);
    case (idx)
      0: return t % 10;
      1: return ((t / 10) % 60) % 10;
      2: return ((t / 10) % 60) / 10;
      3: return ((t / 600) % 60) % 10;
      4: return ((t / 600) % 60) / 10;
      default: return (t / 36000) % (tm + 1);
    endcase
  endfunction

  function automatic int lim(int idx, int tm);
    if (idx == 2 || idx == 4) return 5;
    if (idx == 5) return tm;
    return 9;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic check_inst(int t, int tm, bit ew, bit w,
                            logic [3:0] d0, logic [3:0] d1, logic [3:0] d2,
                            logic [3:0] d3, logic [3:0] d4, logic [3:0] d5);
    int act [6];
    act = '{int'(d0), int'(d1), int'(d2), int'(d3), int'(d4), int'(d5)};
    chk(act[0] == exp_dig(t, 0, tm), "R2 tenths", act[0], exp_dig(t, 0, tm));
    chk(act[1] == exp_dig(t, 1, tm) && act[2] == exp_dig(t, 2, tm), "R6 seconds pair",
        act[2] * 10 + act[1], exp_dig(t, 2, tm) * 10 + exp_dig(t, 1, tm));
    chk(act[3] == exp_dig(t, 3, tm) && act[4] == exp_dig(t, 4, tm), "R5 minutes pair",
        act[4] * 10 + act[3], exp_dig(t, 4, tm) * 10 + exp_dig(t, 3, tm));
    chk(act[5] == exp_dig(t, 5, tm), "R4 top digit", act[5], exp_dig(t, 5, tm));
    chk(w == ew, "R7 wrap flag", int'(w), int'(ew));
    for (int i = 0; i < 6; i++)
      if (act[i] > lim(i, tm)) chk(0, "R8 digit limit", act[i], lim(i, tm));
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      if (done) return;
      check_inst(t0, TOP0, ew0, aw, a0, a1, a2, a3, a4, a5);
      check_inst(t1, TOP1, ew1, bw, b0, b1, b2, b3, b4, b5);
      if (aw) wraps0++;
    end
  endtask

  task automatic check_reset();
    chk({a0, a1, a2, a3, a4, a5, b0, b1, b2, b3, b4, b5} == '0, "R1 digits cleared",
        int'({a5, a4, a3, a2, a1, a0}), 0);
    chk(!aw && !bw, "R1 wrap low", int'({aw, bw}), 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [3:0] snap [6];
    seed = $urandom(32'd2024);
    rst_n = 1'b0; run = 1'b1;
    @(negedge clk); @(negedge clk);
    check_reset();

    // R2: first advance exactly TICK_DIV cycles after release
    rst_n = 1'b1; run = 1'b1;
    step(DIV1 - 1);
    chk(b0 == 4'd0, "R2 no early advance", int'(b0), 0);
    step(1);
    chk(b0 == 4'd1, "R2 first advance", int'(b0), 1);

    // Random run/pause mix
    for (int k = 0; k < 4000; k++) begin
      run = ($urandom % 4) != 0;
      step(1);
    end

    // R3: directed pause, digits frozen
    run = 1'b0;
    step(1);
    snap = '{b0, b1, b2, b3, b4, b5};
    step(40);
    chk(snap == '{b0, b1, b2, b3, b4, b5}, "R3 pause holds", int'(b0), int'(snap[0]));
    chk(snap[0] == b0 && a0 == a0, "R3 pause tenths", int'(b0), int'(snap[0]));

    // Long run: u0 passes 1.59.59.9 and wraps
    run = 1'b1;
    step(75000);
    chk(wraps0 >= 1, "R7 wrap observed", wraps0, 1);

    // Mid-count reset
    rst_n = 1'b0;
    step(1);
    check_reset();
    rst_n = 1'b1;
    for (int k = 0; k < 500; k++) begin
      run = ($urandom % 3) != 0;
      step(1);
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule